// File: doc/BRIEF.md
# Runahead Store Forwarding Cache

This block is a small set-associative store that holds the results of speculative stores retired while a core runs ahead past a long-latency miss, so that later speculative loads can pick those results up. Each byte carries two flags of its own: a written flag that says a speculative store has deposited something there, and a poison flag that says the value deposited is bogus. A load only hits when its line is present and at least one of the bytes it asks for has the written flag. When any requested byte is poisoned, the load gets a poison indication instead of data.

The structure only serves traffic from run-ahead episodes. It never writes anything back: a displaced line is simply forgotten. When the core leaves run-ahead mode, a single-cycle global invalidate empties it. A store whose address itself is bogus is dropped entirely. Loads are answered one cycle after they are presented, from the contents as they stood before any store in the same cycle.

Top module: `rah_fwd_cache`

## Requirements
- R1: With default parameters the array holds 512 bytes as 16 sets of 4 ways with 8-byte lines. The set is address bits [6:3] and the tag is bits [31:7]. Address bits [2:0] are ignored. Bit i of a byte mask selects byte lane i, which is data bits [8i+7:8i].
- R2: A load presented with `ld_en` in one cycle gives `ld_vld`=1 and its result in the next cycle, and `ld_vld` is 0 otherwise, including after reset. The result reflects the contents before any store accepted in the same cycle as the load.
- R3: `ld_hit` is 1 only if a valid line with a matching tag exists in the set and at least one masked byte of that line has its written flag set.
- R4: A store with `st_poison`=0 writes the masked bytes, sets their written flags and clears their poison flags. Unmasked bytes keep their contents and flags.
- R5: A store with `st_poison`=1 sets both the written and the poison flags of the masked bytes.
- R6: On a hit where any masked byte is poisoned, `ld_poison`=1 and `ld_data`=0. On a clean hit, each lane whose byte is masked and written carries the stored byte, and every other lane is 0.
- R7: On a miss, `ld_hit`=0, `ld_poison`=0 and `ld_data`=0.
- R8: `inv_all` clears every line's valid bit and every written flag. It takes priority over a store in the same cycle, so that store is dropped, and a load after it misses.
- R9: A store with `st_addr_bad`=1 changes nothing: no data, no flag, no allocation.
- R10: A store that misses allocates a line in its set. It takes the lowest-numbered invalid way if there is one. Otherwise it takes the way chosen by a tree pseudo-LRU that both stores and load hits update. A newly allocated line starts with all written and poison flags clear, and the displaced line is discarded.
- R11: A line address occupies at most one way of its set. Repeated stores to the same line merge into that one line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inv_all | input | 1 | Empties the whole structure |
| st_en | input | 1 | Store request |
| st_addr | input | 32 | Store byte address |
| st_addr_bad | input | 1 | Store address is bogus; the store is dropped |
| st_mask | input | 8 | Store byte lanes |
| st_data | input | 64 | Store data, by lane |
| st_poison | input | 1 | Store data is bogus |
| ld_en | input | 1 | Load request |
| ld_addr | input | 32 | Load byte address |
| ld_mask | input | 8 | Load byte lanes |
| ld_vld | output | 1 | Load result present |
| ld_hit | output | 1 | Load found stored bytes |
| ld_poison | output | 1 | Load result is bogus |
| ld_data | output | 64 | Load data, by lane |

## Verification
The hardest situation to reach from the ports is a replacement whose victim is not simply the first way. That needs a full set, and a pseudo-LRU tree that has been moved by a load hit after an earlier eviction. The stimulus fills one set with four tags, overflows it once, lets a load hit touch a surviving way, and then overflows it again. It then probes every tag to see which line went. A second corner is a poisoned byte hidden inside a partially written line. It is reached by mixing partial masks across successive stores to one line, and loading with masks that do and do not cover the poisoned lane.

// File: rtl/rah_fwd_pkg.sv
package rah_fwd_pkg;

   // What a store does to the array in a given cycle
   typedef enum logic [1:0] {
      ST_NONE  = 2'd0,
      ST_HIT   = 2'd1,
      ST_ALLOC = 2'd2
   } st_act_e;

endpackage

// File: rtl/rah_fwd_match.sv
module rah_fwd_match #(
   parameter int WAYS  = 4,
   parameter int TAG_W = 25,
   parameter int WAY_W = 2
) (
   input  logic [WAYS-1:0]            line_vld,
   input  logic [WAYS-1:0][TAG_W-1:0] line_tag,
   input  logic [TAG_W-1:0]           tag,
   output logic [WAYS-1:0]            hit_vec,
   output logic                       hit,
   output logic [WAY_W-1:0]           hit_way
);

   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign hit_vec[w] = line_vld[w] && (line_tag[w] == tag);
   end

   assign hit = |hit_vec;

   always_comb begin
      hit_way = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (hit_vec[w]) hit_way = WAY_W'(w);
      end
   end

endmodule

// File: rtl/rah_fwd_repl.sv
module rah_fwd_repl #(
   parameter int WAYS  = 4,
   parameter int SETS  = 16,
   parameter int WAY_W = 2,
   parameter int SET_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             touch_en,
   input  logic [SET_W-1:0] touch_set,
   input  logic [WAY_W-1:0] touch_way,
   input  logic [SET_W-1:0] sel_set,
   output logic [WAY_W-1:0] victim
);

   if (WAYS == 1) begin : g_single
      assign victim = '0;
      logic unused_touch;
      assign unused_touch = ^{clk, rst_n, touch_en, touch_set, touch_way, sel_set};
   end else begin : g_tree
      localparam int NODES = WAYS - 1;
      localparam int LVL   = $clog2(WAYS);

      logic [SETS-1:0][NODES-1:0] tree_q;
      logic [NODES-1:0]           upd;

      // Walk from the root: a node bit of 0 points the victim to the left child
      always_comb begin
         logic [NODES-1:0] cur;
         int unsigned      node;
         logic             b;
         cur    = tree_q[sel_set];
         node   = 0;
         victim = '0;
         for (int l = 0; l < LVL; l++) begin
            b      = |(cur & (NODES'(1) << node));
            victim = (victim << 1) | WAY_W'(b);
            node   = 2 * node + 1 + 32'(b);
         end
      end

      // Point every node on the touched path away from the touched way
      always_comb begin
         logic [WAY_W-1:0] tw;
         int unsigned      node;
         logic             dir;
         upd  = tree_q[touch_set];
         tw   = touch_way;
         node = 0;
         for (int l = 0; l < LVL; l++) begin
            dir  = tw[WAY_W-1];
            tw   = tw << 1;
            upd  = (upd & ~(NODES'(1) << node)) | (NODES'(!dir) << node);
            node = 2 * node + 1 + 32'(dir);
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            tree_q <= '0;
         end else if (touch_en) begin
            tree_q[touch_set] <= upd;
         end
      end
   end

endmodule

// File: rtl/rah_fwd_cache.sv
module rah_fwd_cache
   import rah_fwd_pkg::*;
#(
   parameter int CAP_BYTES  = 512,
   parameter int WAYS       = 4,
   parameter int LINE_BYTES = 8,
   parameter int ADDR_W     = 32,
   localparam int DATA_W    = LINE_BYTES * 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inv_all,
   input  logic              st_en,
   input  logic [ADDR_W-1:0] st_addr,
   input  logic              st_addr_bad,
   input  logic [LINE_BYTES-1:0] st_mask,
   input  logic [DATA_W-1:0] st_data,
   input  logic              st_poison,
   input  logic              ld_en,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic [LINE_BYTES-1:0] ld_mask,
   output logic              ld_vld,
   output logic              ld_hit,
   output logic              ld_poison,
   output logic [DATA_W-1:0] ld_data
);

   localparam int SETS  = CAP_BYTES / (WAYS * LINE_BYTES);
   localparam int OFF_W = $clog2(LINE_BYTES);
   localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1;
   localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
   localparam int TAG_W = ADDR_W - OFF_W - SET_W;

   // Elaboration-time parameter checks
   if ((WAYS & (WAYS - 1)) != 0) begin : g_bad_ways
      $error("WAYS must be a power of two");
   end
   if ((LINE_BYTES & (LINE_BYTES - 1)) != 0 || LINE_BYTES < 2) begin : g_bad_line
      $error("LINE_BYTES must be a power of two of at least 2");
   end
   if (SETS < 2 || (SETS & (SETS - 1)) != 0 || SETS * WAYS * LINE_BYTES != CAP_BYTES) begin : g_bad_sets
      $error("CAP_BYTES must give a power-of-two set count of at least 2");
   end
   if (TAG_W < 1) begin : g_bad_addr
      $error("ADDR_W too small for the geometry");
   end

   // Array state
   logic [SETS-1:0][WAYS-1:0]                 vld_q;
   logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]      tag_q;
   logic [SETS-1:0][WAYS-1:0][LINE_BYTES-1:0][7:0] dat_q;
   logic [SETS-1:0][WAYS-1:0][LINE_BYTES-1:0] sto_q;
   logic [SETS-1:0][WAYS-1:0][LINE_BYTES-1:0] inv_q;

   logic unused_offsets;
   assign unused_offsets = ^{st_addr[OFF_W-1:0], ld_addr[OFF_W-1:0]};

   // ---------------- store side ----------------
   logic [SET_W-1:0] st_set;
   logic [TAG_W-1:0] st_tag;
   logic [WAYS-1:0]  st_hvec;
   logic             st_hit;
   logic [WAY_W-1:0] st_hway;
   logic [WAY_W-1:0] victim;
   logic             free_any;
   logic [WAY_W-1:0] free_way;
   logic [WAY_W-1:0] st_way;
   st_act_e          st_act;

   assign st_set = st_addr[OFF_W +: SET_W];
   assign st_tag = st_addr[ADDR_W-1 -: TAG_W];

   rah_fwd_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_st_match (
      .line_vld (vld_q[st_set]),
      .line_tag (tag_q[st_set]),
      .tag      (st_tag),
      .hit_vec  (st_hvec),
      .hit      (st_hit),
      .hit_way  (st_hway)
   );

   // Lowest-numbered empty way wins
   always_comb begin
      free_any = 1'b0;
      free_way = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (!vld_q[st_set][w]) begin
            free_any = 1'b1;
            free_way = WAY_W'(w);
         end
      end
   end

   always_comb begin
      if (!st_en || st_addr_bad || inv_all) st_act = ST_NONE;
      else if (st_hit)                       st_act = ST_HIT;
      else                                   st_act = ST_ALLOC;
   end

   assign st_way = st_hit ? st_hway : (free_any ? free_way : victim);

   // ---------------- load side ----------------
   logic [SET_W-1:0]      ld_set;
   logic [TAG_W-1:0]      ld_tag;
   logic [WAYS-1:0]       ld_hvec;
   logic                  ld_line;
   logic [WAY_W-1:0]      ld_way;
   logic [LINE_BYTES-1:0] ld_sel;
   logic                  ld_hit_d;
   logic                  ld_poison_d;
   logic [DATA_W-1:0]     ld_data_d;

   assign ld_set = ld_addr[OFF_W +: SET_W];
   assign ld_tag = ld_addr[ADDR_W-1 -: TAG_W];

   rah_fwd_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_ld_match (
      .line_vld (vld_q[ld_set]),
      .line_tag (tag_q[ld_set]),
      .tag      (ld_tag),
      .hit_vec  (ld_hvec),
      .hit      (ld_line),
      .hit_way  (ld_way)
   );

   assign ld_sel      = sto_q[ld_set][ld_way] & ld_mask;
   assign ld_hit_d    = ld_en && ld_line && (|ld_sel);
   assign ld_poison_d = ld_hit_d && (|(inv_q[ld_set][ld_way] & ld_mask));

   for (genvar b = 0; b < LINE_BYTES; b++) begin : g_lane
      assign ld_data_d[8*b +: 8] = (ld_hit_d && !ld_poison_d && ld_sel[b])
                                   ? dat_q[ld_set][ld_way][b] : 8'h00;
   end

   // ---------------- replacement ----------------
   logic             touch_en;
   logic [SET_W-1:0] touch_set;
   logic [WAY_W-1:0] touch_way;

   assign touch_en  = (st_act != ST_NONE) || (ld_hit_d && !inv_all);
   assign touch_set = (st_act != ST_NONE) ? st_set : ld_set;
   assign touch_way = (st_act != ST_NONE) ? st_way : ld_way;

   rah_fwd_repl #(.WAYS(WAYS), .SETS(SETS), .WAY_W(WAY_W), .SET_W(SET_W)) u_repl (
      .clk       (clk),
      .rst_n     (rst_n),
      .touch_en  (touch_en),
      .touch_set (touch_set),
      .touch_way (touch_way),
      .sel_set   (st_set),
      .victim    (victim)
   );

   // ---------------- array update ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= '0;
         tag_q <= '0;
         dat_q <= '0;
         sto_q <= '0;
         inv_q <= '0;
      end else if (inv_all) begin
         vld_q <= '0;
         sto_q <= '0;
      end else begin
         case (st_act)
            ST_ALLOC: begin
               vld_q[st_set][st_way] <= 1'b1;
               tag_q[st_set][st_way] <= st_tag;
               for (int b = 0; b < LINE_BYTES; b++) begin
                  sto_q[st_set][st_way][b] <= st_mask[b];
                  inv_q[st_set][st_way][b] <= st_mask[b] && st_poison;
                  if (st_mask[b] && !st_poison)
                     dat_q[st_set][st_way][b] <= st_data[8*b +: 8];
               end
            end
            ST_HIT: begin
               for (int b = 0; b < LINE_BYTES; b++) begin
                  if (st_mask[b]) begin
                     sto_q[st_set][st_way][b] <= 1'b1;
                     inv_q[st_set][st_way][b] <= st_poison;
                     if (!st_poison)
                        dat_q[st_set][st_way][b] <= st_data[8*b +: 8];
                  end
               end
            end
            default: ;
         endcase
      end
   end

   // ---------------- load result register ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ld_vld    <= 1'b0;
         ld_hit    <= 1'b0;
         ld_poison <= 1'b0;
         ld_data   <= '0;
      end else begin
         ld_vld    <= ld_en;
         ld_hit    <= ld_hit_d;
         ld_poison <= ld_poison_d;
         ld_data   <= ld_data_d;
      end
   end

   // ---------------- assertions ----------------
   AST_RESULT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      ld_en |=> ld_vld);                                                   // R2
   AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_en |=> !ld_vld);                                                 // R2
   AST_POISON_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      ld_poison |-> (ld_hit && ld_data == '0));                            // R6
   AST_MISS_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_vld && !ld_hit) |-> (!ld_poison && ld_data == '0));              // R7
   AST_EMPTY_AFTER_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(inv_all) && ld_en) |=> !ld_hit);                              // R8
   AST_BAD_ADDR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (st_en && st_addr_bad && !inv_all) |=> ($stable(vld_q) && $stable(sto_q) && $stable(inv_q)));  // R9
   AST_SINGLE_WAY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ld_hvec) && $onehot0(st_hvec));                             // R11

endmodule

// File: tb/rah_fwd_cache_test.sv
`timescale 1ns/1ps
module rah_fwd_cache_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        inv_all = 1'b0;
   logic        st_en = 1'b0;
   logic [31:0] st_addr = '0;
   logic        st_addr_bad = 1'b0;
   logic [7:0]  st_mask = '0;
   logic [63:0] st_data = '0;
   logic        st_poison = 1'b0;
   logic        ld_en = 1'b0;
   logic [31:0] ld_addr = '0;
   logic [7:0]  ld_mask = '0;
   logic        ld_vld;
   logic        ld_hit;
   logic        ld_poison;
   logic [63:0] ld_data;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   rah_fwd_cache uut (
      .clk(clk), .rst_n(rst_n), .inv_all(inv_all),
      .st_en(st_en), .st_addr(st_addr), .st_addr_bad(st_addr_bad),
      .st_mask(st_mask), .st_data(st_data), .st_poison(st_poison),
      .ld_en(ld_en), .ld_addr(ld_addr), .ld_mask(ld_mask),
      .ld_vld(ld_vld), .ld_hit(ld_hit), .ld_poison(ld_poison), .ld_data(ld_data)
   );

   typedef struct {
      logic        hit;
      logic        poison;
      logic [63:0] data;
      string       req;
   } exp_t;

   exp_t sb[$];

   // tag in bits [31:7], set in [6:3], offset in [2:0]
   function automatic logic [31:0] mk(input int tag, input int set, input int off);
      return {25'(tag), 4'(set), 3'(off)};
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // Monitor: pops one expected item per returned load result
   always @(negedge clk) begin
      if (rst_n && ld_vld && !finished) begin
         if (sb.size() == 0) begin
            check(1'b0, "R2", "result with nothing pending", 64'(ld_vld), 64'h0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            check(ld_hit == e.hit, e.req, "hit", 64'(ld_hit), 64'(e.hit));
            check(ld_poison == e.poison, e.req, "poison", 64'(ld_poison), 64'(e.poison));
            check(ld_data == e.data, e.req, "data", ld_data, e.data);
         end
      end
   end

   task automatic push_exp(input logic h, input logic p, input logic [63:0] d, input string req);
      exp_t e;
      e.hit = h; e.poison = p; e.data = d; e.req = req;
      sb.push_back(e);
   endtask

   task automatic do_store(input logic [31:0] a, input logic [7:0] m, input logic [63:0] d,
                           input logic pois, input logic bad);
      st_en = 1'b1; st_addr = a; st_mask = m; st_data = d; st_poison = pois; st_addr_bad = bad;
      @(negedge clk);
      st_en = 1'b0; st_poison = 1'b0; st_addr_bad = 1'b0;
   endtask

   task automatic do_load(input logic [31:0] a, input logic [7:0] m,
                          input logic h, input logic p, input logic [63:0] d, input string req);
      ld_en = 1'b1; ld_addr = a; ld_mask = m;
      push_exp(h, p, d, req);
      @(negedge clk);
      ld_en = 1'b0;
   endtask

   task automatic settle();
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected done");
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // Reset state, R2 / R7
      check(ld_vld == 1'b0, "R2", "ld_vld after reset", 64'(ld_vld), 64'h0);
      check(ld_hit == 1'b0 && ld_data == '0, "R7", "outputs after reset", ld_data, 64'h0);

      // R7: empty array misses
      do_load(mk(1,0,0), 8'hFF, 0, 0, 64'h0, "R7");

      // R4: full-line valid store then load
      do_store(mk(1,0,0), 8'hFF, 64'h1111_2222_3333_4444, 0, 0);
      do_load(mk(1,0,0), 8'hFF, 1, 0, 64'h1111_2222_3333_4444, "R4");

      // R1: offset ignored, other tag / other set miss
      do_load(mk(1,0,5), 8'hFF, 1, 0, 64'h1111_2222_3333_4444, "R1");
      do_load(mk(2,0,0), 8'hFF, 0, 0, 64'h0, "R1");
      do_load(mk(1,1,0), 8'hFF, 0, 0, 64'h0, "R1");

      // R3 / R10: new line starts with written flags clear
      do_store(mk(3,2,0), 8'h03, 64'hFFFF_FFFF_FFFF_AABB, 0, 0);
      do_load(mk(3,2,0), 8'hF0, 0, 0, 64'h0, "R3");
      do_load(mk(3,2,0), 8'h0F, 1, 0, 64'h0000_0000_0000_AABB, "R3");

      // R5 / R6: poison one byte
      do_store(mk(1,0,0), 8'h04, 64'hDEAD_BEEF_DEAD_BEEF, 1, 0);
      do_load(mk(1,0,0), 8'h04, 1, 1, 64'h0, "R5");
      do_load(mk(1,0,0), 8'h0F, 1, 1, 64'h0, "R6");
      do_load(mk(1,0,0), 8'h03, 1, 0, 64'h0000_0000_0000_4444, "R6");
      // R4: valid store clears poison
      do_store(mk(1,0,0), 8'h04, 64'h0000_0000_005A_0000, 0, 0);
      do_load(mk(1,0,0), 8'hFF, 1, 0, 64'h1111_2222_335A_4444, "R4");

      // R9: bogus-address store has no effect
      do_store(mk(1,0,0), 8'hFF, 64'h0, 0, 1);
      do_load(mk(1,0,0), 8'hFF, 1, 0, 64'h1111_2222_335A_4444, "R9");
      do_store(mk(4,3,0), 8'hFF, 64'h0123_4567_89AB_CDEF, 0, 1);
      do_load(mk(4,3,0), 8'hFF, 0, 0, 64'h0, "R9");

      // R2: load in the same cycle as a store sees the old contents
      st_en = 1'b1; st_addr = mk(5,4,0); st_mask = 8'hFF; st_data = 64'h5555_6666_7777_8888;
      ld_en = 1'b1; ld_addr = mk(5,4,0); ld_mask = 8'hFF;
      push_exp(0, 0, 64'h0, "R2");
      @(negedge clk);
      st_en = 1'b0; ld_en = 1'b0;
      do_load(mk(5,4,0), 8'hFF, 1, 0, 64'h5555_6666_7777_8888, "R2");

      // R11: two partial stores merge into one line
      do_store(mk(6,6,0), 8'h0F, 64'hFFFF_FFFF_0102_0304, 0, 0);
      do_store(mk(6,6,0), 8'hF0, 64'h0506_0708_FFFF_FFFF, 0, 0);
      do_load(mk(6,6,0), 8'hFF, 1, 0, 64'h0506_0708_0102_0304, "R11");

      // R10: replacement in set 9
      do_store(mk(16,9,0), 8'hFF, {8{8'h10}}, 0, 0);
      do_store(mk(17,9,0), 8'hFF, {8{8'h11}}, 0, 0);
      do_store(mk(18,9,0), 8'hFF, {8{8'h12}}, 0, 0);
      do_store(mk(19,9,0), 8'hFF, {8{8'h13}}, 0, 0);
      do_store(mk(20,9,0), 8'hFF, {8{8'h14}}, 0, 0);   // evicts way 0 (tag 16)
      do_load(mk(16,9,0), 8'hFF, 0, 0, 64'h0, "R10");
      do_load(mk(17,9,0), 8'hFF, 1, 0, {8{8'h11}}, "R10"); // touches way 1
      do_store(mk(21,9,0), 8'hFF, {8{8'h15}}, 0, 0);   // evicts way 2 (tag 18)
      do_load(mk(18,9,0), 8'hFF, 0, 0, 64'h0, "R10");
      do_load(mk(19,9,0), 8'hFF, 1, 0, {8{8'h13}}, "R10");
      do_load(mk(20,9,0), 8'hFF, 1, 0, {8{8'h14}}, "R10");
      do_load(mk(21,9,0), 8'hFF, 1, 0, {8{8'h15}}, "R10");

      // R8: global invalidate
      inv_all = 1'b1;
      @(negedge clk);
      inv_all = 1'b0;
      do_load(mk(1,0,0), 8'hFF, 0, 0, 64'h0, "R8");
      do_load(mk(19,9,0), 8'hFF, 0, 0, 64'h0, "R8");
      inv_all = 1'b1;
      do_store(mk(7,0,0), 8'hFF, 64'hCAFE_CAFE_CAFE_CAFE, 0, 0);
      inv_all = 1'b0;
      do_load(mk(7,0,0), 8'hFF, 0, 0, 64'h0, "R8");
      do_store(mk(7,0,0), 8'hFF, 64'hCAFE_CAFE_CAFE_CAFE, 0, 0);
      do_load(mk(7,0,0), 8'hFF, 1, 0, 64'hCAFE_CAFE_CAFE_CAFE, "R8");

      settle();
      check(sb.size() == 0, "R2", "pending results", 64'(sb.size()), 64'h0);
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule